// File: doc/BRIEF.md
# DDR3 Read Burst Timing Tracker

This block sits on the controller side of a DDR3 memory interface and predicts, cycle by cycle, when the data of each issued READ comes back. It watches the command stream. Each READ is placed in a small in-flight queue together with a countdown of the read latency, its burst length and its starting column. The read latency is the additive latency plus the CAS latency. When a countdown expires, the block drives a data-valid flag for every clock that carries data. Data moves on both clock edges, so every clock carries two beats. For each clock the block reports the beat index and the columns of the even and the odd beat. It also flags the final clock of the burst and the strobe preamble and postamble windows around it.

The burst length is resolved per command. A two-bit mode setting either fixes it or lets a dedicated address bit choose between an 8-beat burst and a 4-beat chopped burst. That address bit never enters the column arithmetic. Reads can be issued back to back, and consecutive 8-beat bursts spaced four clocks apart stream with no gap. A READ that finds the queue full is dropped and reported.

Top module: `rd_burst_tracker`

## Requirements
- R1: A READ sampled in clock cycle 0 produces its first data cycle (rd_valid high) in cycle RL, where RL = mr_add_lat + mr_cas_lat and RL is at least 2.
- R2: With mr_burst_mode = 2'b01, addr_bc_sel = 1 selects an 8-beat burst (4 data cycles) and addr_bc_sel = 0 selects a chopped 4-beat burst (2 data cycles, beat_idx only 0 and 2).
- R3: With mr_burst_mode = 2'b00 every READ is an 8-beat burst, and with 2'b10 every READ is a chopped 4-beat burst, whatever addr_bc_sel is.
- R4: With mr_burst_mode = 2'b11 the READ is an 8-beat burst, and mode_err is high for the one cycle that follows the READ.
- R5: In each data cycle beat_idx is the index of the even beat (0, 2, 4, 6 in order), beat_col_even = start column + beat_idx and beat_col_odd = start column + beat_idx + 1, both modulo 2^COL_W. addr_bc_sel does not enter either column.
- R6: last_beat is high exactly in the final data cycle of each burst.
- R7: preamble is high in the cycle right before a burst's first data cycle when that cycle carries no data. It stays low when the burst follows another burst with no gap.
- R8: postamble is high in the cycle after a burst's last data cycle when that cycle carries no data.
- R9: Two 8-beat READs spaced four cycles apart give eight consecutive data cycles, with beat_idx restarting at 0 on the fifth.
- R10: The queue holds QDEPTH READs. A READ arriving while QDEPTH reads are pending is dropped and never returns data, and q_overflow is high for the following cycle.
- R11: A command with cmd_valid high and cmd_is_read low produces no data, preamble or postamble.
- R12: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_is_read | input | 1 | The issued command decodes as READ |
| addr_bc_sel | input | 1 | Burst select address bit sampled with the READ |
| col_addr | input | COL_W | Starting column of the READ |
| mr_burst_mode | input | 2 | Burst mode: 00 fixed 8, 01 per command, 10 fixed chop 4, 11 reserved |
| mr_add_lat | input | LAT_W | Additive latency in clocks |
| mr_cas_lat | input | LAT_W | CAS latency in clocks |
| rd_valid | output | 1 | This clock carries two read beats |
| beat_idx | output | 3 | Index of the even beat in this clock |
| beat_col_even | output | COL_W | Column of the even beat |
| beat_col_odd | output | COL_W | Column of the odd beat |
| preamble | output | 1 | Read preamble window |
| postamble | output | 1 | Read postamble window |
| last_beat | output | 1 | Final data clock of the burst |
| mode_err | output | 1 | A READ was issued under the reserved burst mode |
| q_overflow | output | 1 | A READ was dropped because the queue was full |

## Verification
A countdown that is off by one moves a whole burst by a cycle. This shows up at the READ's first expected data cycle as a missing or early rd_valid, and the preamble moves with it. A wrong burst-length bit in a queue entry shows up when the burst should end: a chopped burst runs to beat 6, or an 8-beat burst stops after beat 2 with last_beat and postamble moved. A corrupted queue pointer or fill count shows up in back-to-back or full-queue traffic: a burst repeats or vanishes, or q_overflow fires on the wrong READ within a few cycles of the queue filling.

// File: rtl/rd_burst_tracker.sv
module rd_burst_tracker #(
  parameter int COL_W  = 10,
  parameter int LAT_W  = 5,
  parameter int QDEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_is_read,
  input  logic             addr_bc_sel,
  input  logic [COL_W-1:0] col_addr,
  input  logic [1:0]       mr_burst_mode,
  input  logic [LAT_W-1:0] mr_add_lat,
  input  logic [LAT_W-1:0] mr_cas_lat,
  output logic             rd_valid,
  output logic [2:0]       beat_idx,
  output logic [COL_W-1:0] beat_col_even,
  output logic [COL_W-1:0] beat_col_odd,
  output logic             preamble,
  output logic             postamble,
  output logic             last_beat,
  output logic             mode_err,
  output logic             q_overflow
);
  localparam int PTR_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int FILL_W = $clog2(QDEPTH + 1);
  localparam int CNT_W  = LAT_W + 1;

  logic [QDEPTH-1:0] e_vld;
  logic [QDEPTH-1:0] e_bc;
  logic [CNT_W-1:0]  e_cnt [QDEPTH];
  logic [COL_W-1:0]  e_col [QDEPTH];
  logic [1:0]        e_bp  [QDEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [FILL_W-1:0] fill;
  logic              last_q, ovf_q, err_q;

  logic             is_rd, full, push, pop, bc_new, head_data, pre_any;
  logic [CNT_W-1:0] rl;
  logic [1:0]       head_bp;
  logic [COL_W-1:0] col_base;

  assign is_rd     = cmd_valid & cmd_is_read;
  assign full      = (fill == FILL_W'(QDEPTH));
  assign push      = is_rd & ~full;
  assign bc_new    = (mr_burst_mode == 2'b10) | ((mr_burst_mode == 2'b01) & ~addr_bc_sel);
  assign rl        = CNT_W'(mr_add_lat) + CNT_W'(mr_cas_lat);
  assign head_bp   = e_bp[rd_ptr];
  assign head_data = e_vld[rd_ptr] && (e_cnt[rd_ptr] == '0);
  assign pop       = head_data && (head_bp == (e_bc[rd_ptr] ? 2'd1 : 2'd3));

  always_comb begin
    pre_any = 1'b0;
    for (int i = 0; i < QDEPTH; i++)
      if (e_vld[i] && e_cnt[i] == CNT_W'(1)) pre_any = 1'b1;
  end

  assign col_base      = e_col[rd_ptr] + COL_W'({head_bp, 1'b0});
  assign rd_valid      = head_data;
  assign beat_idx      = head_data ? {head_bp, 1'b0} : 3'd0;
  assign beat_col_even = head_data ? col_base : '0;
  assign beat_col_odd  = head_data ? col_base + COL_W'(1) : '0;
  assign last_beat     = pop;
  assign preamble      = pre_any & ~head_data;
  assign postamble     = last_q & ~head_data;
  assign mode_err      = err_q;
  assign q_overflow    = ovf_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QDEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld  <= '0;
      e_bc   <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
      last_q <= 1'b0;
      ovf_q  <= 1'b0;
      err_q  <= 1'b0;
      for (int i = 0; i < QDEPTH; i++) begin
        e_cnt[i] <= '0;
        e_col[i] <= '0;
        e_bp[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < QDEPTH; i++)
        if (e_vld[i] && e_cnt[i] != '0) e_cnt[i] <= e_cnt[i] - CNT_W'(1);
      if (head_data) begin
        if (pop) begin
          e_vld[rd_ptr] <= 1'b0;
          e_bp[rd_ptr]  <= 2'd0;
          rd_ptr        <= ptr_inc(rd_ptr);
        end else begin
          e_bp[rd_ptr]  <= head_bp + 2'd1;
        end
      end
      if (push) begin
        e_vld[wr_ptr] <= 1'b1;
        e_bc[wr_ptr]  <= bc_new;
        e_cnt[wr_ptr] <= rl - CNT_W'(1);
        e_col[wr_ptr] <= col_addr;
        e_bp[wr_ptr]  <= 2'd0;
        wr_ptr        <= ptr_inc(wr_ptr);
      end
      fill   <= fill + FILL_W'(push) - FILL_W'(pop);
      last_q <= pop;
      ovf_q  <= is_rd & full;
      err_q  <= push & (mr_burst_mode == 2'b11);
    end
  end

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !last_beat |=> rd_valid && beat_idx == $past(beat_idx) + 3'd2); // R5
  AST_LAST_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> !rd_valid || beat_idx == 3'd0); // R6
  AST_CHOP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && e_bc[rd_ptr] |-> beat_idx < 3'd4); // R2
  AST_POST_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    postamble |-> $past(last_beat)); // R8
  AST_PRE_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    preamble |=> rd_valid); // R7
  AST_NO_OVERFLOW_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    q_overflow |-> $past(cmd_valid && cmd_is_read)); // R10
endmodule

// File: tb/rd_burst_tracker_tb_top.sv
module rd_burst_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 10;
  localparam int LAT_W = 5;
  localparam int LOGN  = 2048;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_is_read = 0, addr_bc_sel = 0;
  logic [COL_W-1:0] col_addr = '0;
  logic [1:0] mr_burst_mode = 2'b01;
  logic [LAT_W-1:0] mr_add_lat = '0, mr_cas_lat = 5'd6;
  logic rd_valid, preamble, postamble, last_beat, mode_err, q_overflow;
  logic [2:0] beat_idx;
  logic [COL_W-1:0] beat_col_even, beat_col_odd;

  rd_burst_tracker #(.COL_W(COL_W), .LAT_W(LAT_W), .QDEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_read(cmd_is_read),
    .addr_bc_sel(addr_bc_sel), .col_addr(col_addr), .mr_burst_mode(mr_burst_mode),
    .mr_add_lat(mr_add_lat), .mr_cas_lat(mr_cas_lat), .rd_valid(rd_valid),
    .beat_idx(beat_idx), .beat_col_even(beat_col_even), .beat_col_odd(beat_col_odd),
    .preamble(preamble), .postamble(postamble), .last_beat(last_beat),
    .mode_err(mode_err), .q_overflow(q_overflow));

  always #(CLK_PERIOD/2) clk = ~clk;

  int ecount = 0;
  always @(posedge clk) ecount <= ecount + 1;

  int lv[LOGN], lidx[LOGN], lc0[LOGN], lc1[LOGN], lpre[LOGN], lpost[LOGN];
  int llast[LOGN], lerr[LOGN], lovf[LOGN];
  always @(negedge clk) if (ecount < LOGN) begin
    lv[ecount] = int'(rd_valid);     lidx[ecount] = int'(beat_idx);
    lc0[ecount] = int'(beat_col_even); lc1[ecount] = int'(beat_col_odd);
    lpre[ecount] = int'(preamble);   lpost[ecount] = int'(postamble);
    llast[ecount] = int'(last_beat); lerr[ecount] = int'(mode_err);
    lovf[ecount] = int'(q_overflow);
  end

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input bit rd, input bit a12, input int col, output int e0);
    cmd_valid = 1; cmd_is_read = rd; addr_bc_sel = a12; col_addr = COL_W'(col);
    @(negedge clk);
    cmd_valid = 0; cmd_is_read = 0; addr_bc_sel = 0;
    e0 = ecount;
  endtask

  task automatic set_mode(input bit [1:0] bm, input int al, input int cl);
    mr_burst_mode = bm; mr_add_lat = LAT_W'(al); mr_cas_lat = LAT_W'(cl);
  endtask

  task automatic check_burst(input int e0, input int rl, input bit bl8, input int col, input string req);
    int pairs = bl8 ? 4 : 2;
    for (int p = 0; p < pairs; p++) begin
      int k = e0 + rl - 1 + p;
      chk(lv[k] == 1, req, "rd_valid", lv[k], 1);
      chk(lidx[k] == 2*p, req, "beat_idx", lidx[k], 2*p);
      chk(lc0[k] == ((col + 2*p) % 1024), req, "col even", lc0[k], (col + 2*p) % 1024);
      chk(lc1[k] == ((col + 2*p + 1) % 1024), req, "col odd", lc1[k], (col + 2*p + 1) % 1024);
      chk(llast[k] == int'(p == pairs-1), req, "last_beat", llast[k], int'(p == pairs-1));
    end
  endtask

  task automatic t_reset;
    idle(1);
    chk(rd_valid == 0 && preamble == 0 && postamble == 0 && last_beat == 0 &&
        mode_err == 0 && q_overflow == 0 && beat_idx == 0 && beat_col_even == 0 &&
        beat_col_odd == 0, "R12", "outputs in reset", int'(rd_valid), 0);
  endtask

  task automatic t_basic_bl8;
    int e0;
    set_mode(2'b01, 0, 6);
    issue(1, 1, 'h40, e0);
    idle(14);
    chk(lv[e0+4] == 0, "R1", "no early data", lv[e0+4], 0);
    check_burst(e0, 6, 1, 'h40, "R1 R2 R5 R6");
    chk(lpre[e0+4] == 1, "R7", "preamble", lpre[e0+4], 1);
    chk(lpre[e0+3] == 0, "R7", "preamble one cycle", lpre[e0+3], 0);
    chk(lpost[e0+9] == 1, "R8", "postamble", lpost[e0+9], 1);
    chk(lv[e0+9] == 0, "R2", "burst ends after 4 cycles", lv[e0+9], 0);
  endtask

  task automatic t_chop_wrap;
    int e0;
    set_mode(2'b01, 0, 6);
    issue(1, 0, 'h3FE, e0);
    idle(12);
    check_burst(e0, 6, 0, 'h3FE, "R2 R5");
    chk(lv[e0+7] == 0, "R2", "chop ends after 2 cycles", lv[e0+7], 0);
    chk(lpost[e0+7] == 1, "R8", "chop postamble", lpost[e0+7], 1);
  endtask

  task automatic t_additive;
    int e0;
    set_mode(2'b01, 5, 6);
    issue(1, 1, 'h10, e0);
    idle(20);
    chk(lv[e0+9] == 0, "R1", "no data before RL 11", lv[e0+9], 0);
    chk(lpre[e0+9] == 1, "R7", "preamble at RL 11", lpre[e0+9], 1);
    check_burst(e0, 11, 1, 'h10, "R1");
  endtask

  task automatic t_fixed_modes;
    int e0;
    set_mode(2'b00, 0, 6);
    issue(1, 0, 'h80, e0);
    idle(14);
    check_burst(e0, 6, 1, 'h80, "R3");
    set_mode(2'b10, 0, 6);
    issue(1, 1, 'h90, e0);
    idle(14);
    check_burst(e0, 6, 0, 'h90, "R3");
    chk(lv[e0+7] == 0, "R3", "fixed chop ends", lv[e0+7], 0);
  endtask

  task automatic t_reserved;
    int e0;
    set_mode(2'b11, 0, 6);
    issue(1, 0, 'h20, e0);
    idle(14);
    chk(lerr[e0] == 1, "R4", "mode_err pulse", lerr[e0], 1);
    chk(lerr[e0+1] == 0, "R4", "mode_err one cycle", lerr[e0+1], 0);
    check_burst(e0, 6, 1, 'h20, "R4");
    set_mode(2'b01, 0, 6);
  endtask

  task automatic t_b2b_bl8;
    int e0, e1;
    set_mode(2'b01, 0, 6);
    issue(1, 1, 'h100, e0);
    idle(3);
    issue(1, 1, 'h200, e1);
    idle(16);
    chk(e1 - e0 == 4, "R9", "spacing", e1 - e0, 4);
    check_burst(e0, 6, 1, 'h100, "R9");
    check_burst(e1, 6, 1, 'h200, "R9");
    chk(lpre[e1+4] == 0, "R7", "no preamble seamless", lpre[e1+4], 0);
    chk(lpost[e0+9] == 0, "R8", "no postamble seamless", lpost[e0+9], 0);
    chk(lpost[e1+9] == 1, "R8", "final postamble", lpost[e1+9], 1);
  endtask

  task automatic t_b2b_chop;
    int e0, e1;
    set_mode(2'b01, 0, 6);
    issue(1, 0, 'h30, e0);
    idle(3);
    issue(1, 0, 'h50, e1);
    idle(14);
    check_burst(e0, 6, 0, 'h30, "R2");
    check_burst(e1, 6, 0, 'h50, "R2");
    chk(lpost[e0+7] == 1, "R8", "gap postamble", lpost[e0+7], 1);
    chk(lpre[e0+8] == 1, "R7", "gap preamble", lpre[e0+8], 1);
  endtask

  task automatic t_overflow;
    int e[5];
    set_mode(2'b01, 0, 20);
    for (int i = 0; i < 5; i++) begin
      issue(1, 1, 16*i, e[i]);
      if (i < 4) idle(3);
    end
    idle(40);
    chk(lovf[e[4]] == 1, "R10", "overflow pulse", lovf[e[4]], 1);
    chk(lovf[e[3]] == 0, "R10", "no overflow on 4th", lovf[e[3]], 0);
    for (int i = 0; i < 4; i++) check_burst(e[i], 20, 1, 16*i, "R10");
    chk(lv[e[3]+23] == 0, "R10", "dropped read returns nothing", lv[e[3]+23], 0);
    chk(lpost[e[3]+23] == 1, "R10", "stream ends after 4 bursts", lpost[e[3]+23], 1);
  endtask

  task automatic t_non_read;
    int e0, seen;
    set_mode(2'b01, 0, 6);
    issue(0, 1, 'h55, e0);
    idle(14);
    seen = 0;
    for (int k = e0; k < e0 + 12; k++) seen += lv[k] + lpre[k] + lpost[k];
    chk(seen == 0, "R11", "activity after non-read", seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    idle(2);
    rst_n = 1;
    idle(2);
    t_basic_bl8();
    t_chop_wrap();
    t_additive();
    t_fixed_modes();
    t_reserved();
    t_b2b_bl8();
    t_b2b_chop();
    t_overflow();
    t_non_read();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule